// File: doc/BRIEF.md
# Two-Source Video Blend Pipeline

This block blends two video samples, A and B, under a mix coefficient M and produces `2*(A*M + B*(1-M))` on a 13-bit result bus. It is fully pipelined and accepts a new sample on every clock. M is an unsigned fixed-point value with one integer bit and eleven fraction bits, so it spans 0.0 to 1.0. Any coefficient whose top bit is set is taken as exactly 1.0. The coefficient is held in a register that loads only while the mix enable is high. This lets a constant blend ratio be set once and then left in place.

Each sample carries its own number format (unsigned or two's complement) and its own output precision. Both selects are registered with the sample and travel down the pipeline beside it, so a change affects only the samples that enter on or after that clock. The exact pre-rounding value is the floor of the blend. It is then rounded to 8, 10, 12 or 13 significant bits. Rounding adds one half of the kept LSB and clears the bits below it. A sum that no longer fits in the 13-bit range is clamped. A valid flag follows each sample to the output. A separate output-enable input is registered once and presented as a flag.

Top module: `vmix_blend`

## Requirements
- R1: `dout` equals floor(2*(A*M + B*(1-M))) after rounding, where M = m_in/2048. A sample sampled at clock edge k appears after edge k+4, and `out_vld` after edge k+4 equals the `in_vld` sampled at edge k.
- R2: When bit 11 of the stored coefficient is 1, M is exactly 1.0 and the lower eleven bits are ignored, so m_in = 12'h800 and m_in = 12'hFFF give the same result.
- R3: While `mix_en` = 0, `m_in` has no effect and the last coefficient loaded while `mix_en` = 1 stays in use. A sample presented together with `mix_en` = 1 uses the m_in of that same clock.
- R4: `fmt_uns` = 1 treats A, B and `dout` as unsigned. `fmt_uns` = 0 treats all three as two's complement. The select applies only to the sample entering in the same clock.
- R5: `rnd_sel` sets the significant bits of `dout` per sample: 2'b00 gives 8 bits (bits 4:0 cleared), 2'b01 gives 10 bits (bits 2:0 cleared), 2'b10 gives 12 bits (bit 0 cleared), and 2'b11 passes the 13-bit value through unchanged.
- R6: Rounding adds 1 at the bit just below the kept LSB (bit 4, 2 or 0 for the three reduced settings) before the lower bits are cleared.
- R7: If that addition exceeds the format's range, `dout` is clamped to 8191 (unsigned) or 4095 (two's complement).
- R8: A synchronous active-high `rst` clears the pipeline, the stored coefficient (to 0.0), `dout`, `out_vld` and `out_drive`.
- R9: `out_drive` equals `out_en` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks the incoming sample valid |
| a_in | input | 12 | Sample A |
| b_in | input | 12 | Sample B |
| m_in | input | 12 | Mix coefficient, 1 integer + 11 fraction bits |
| mix_en | input | 1 | Loads m_in into the coefficient register |
| fmt_uns | input | 1 | 1 = unsigned, 0 = two's complement |
| rnd_sel | input | 2 | Output precision select |
| out_en | input | 1 | Output-enable request |
| dout | output | 13 | Rounded blend result |
| out_vld | output | 1 | Valid flag delayed with its sample |
| out_drive | output | 1 | Registered output enable |

## Verification
The bench builds the block with its default widths: 12-bit samples and coefficient, and a 13-bit result. At these widths every rounding setting drops a distinct number of bits (5, 3, 1, 0), and both clamp values can be reached. Full-scale inputs in both formats push the rounding addition past the range. The coefficient values 12'h800 and 12'hFFF land exactly on the saturation boundary. A reference function computes each expected value, and the bench drives per-sample changes of format and precision so that misaligned select pipelines show up.

// File: rtl/vmix_pkg.sv
package vmix_pkg;

   typedef enum logic [1:0] {
      RND_KEEP8  = 2'b00,
      RND_KEEP10 = 2'b01,
      RND_KEEP12 = 2'b10,
      RND_FULL   = 2'b11
   } rnd_sel_e;

   // Per-sample side information that rides along with the data
   typedef struct packed {
      logic       vld;
      logic       fmt_uns;
      logic [1:0] rnd;
   } smp_tag_t;

endpackage

// File: rtl/vmix_coef.sv
module vmix_coef #(
   parameter int MW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mix_en,
   input  logic [MW-1:0] m_in,
   output logic [MW-1:0] m_eff,
   output logic [MW-1:0] m_inv
);
   localparam logic [MW-1:0] ONE = {1'b1, {(MW-1){1'b0}}};

   logic [MW-1:0] m_q;
   logic [MW-1:0] eff_d;

   // coefficient holding register, loaded only while enabled
   always_ff @(posedge clk) begin
      if (rst)         m_q <= '0;
      else if (mix_en) m_q <= m_in;
   end

   // saturate: integer bit set means exactly 1.0
   always_comb begin
      if (m_q[MW-1]) eff_d = ONE;
      else           eff_d = {1'b0, m_q[MW-2:0]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_eff <= '0;
         m_inv <= '0;
      end else begin
         m_eff <= eff_d;
         m_inv <= ONE - eff_d;
      end
   end

   AST_M_HOLD: assert property (@(posedge clk) disable iff (rst)
      !mix_en |=> $stable(m_q)); // R3

   AST_M_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (mix_en && m_in[MW-1]) |-> ##2 (m_eff == ONE && m_inv == '0)); // R2

endmodule

// File: rtl/vmix_mac.sv
module vmix_mac #(
   parameter int DW = 12,
   parameter int MW = 12,
   parameter int OW = DW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic signed [DW:0] a_x,
   input  logic signed [DW:0] b_x,
   input  logic [MW-1:0]     m_eff,
   input  logic [MW-1:0]     m_inv,
   output logic [OW-1:0]     val
);
   localparam int PW = DW + MW + 2;
   localparam int SH = MW - 2;

   logic signed [MW:0]   c_eff, c_inv;
   logic signed [PW-1:0] pa_q, pb_q;
   logic signed [PW:0]   acc;

   assign c_eff = $signed({1'b0, m_eff});
   assign c_inv = $signed({1'b0, m_inv});

   // stage: both partial products
   always_ff @(posedge clk) begin
      if (rst) begin
         pa_q <= '0;
         pb_q <= '0;
      end else begin
         pa_q <= a_x * c_eff;
         pb_q <= b_x * c_inv;
      end
   end

   assign acc = $signed({pa_q[PW-1], pa_q}) + $signed({pb_q[PW-1], pb_q});

   // stage: sum, doubling folded into the shift, floor truncation
   always_ff @(posedge clk) begin
      if (rst) val <= '0;
      else     val <= OW'(acc >>> SH);
   end

   AST_PROD_NONNEG: assert property (@(posedge clk) disable iff (rst)
      (!a_x[DW] && !b_x[DW]) |=> (!pa_q[PW-1] && !pb_q[PW-1])); // R4

endmodule

// File: rtl/vmix_round.sv
module vmix_round
   import vmix_pkg::*;
#(
   parameter int OW = 13
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [OW-1:0] val,
   input  smp_tag_t      tag_i,
   output logic [OW-1:0] dout,
   output logic          dvld
);
   localparam logic [OW-1:0] CLAMP_U = {OW{1'b1}};
   localparam logic [OW-1:0] CLAMP_S = {1'b0, {(OW-1){1'b1}}};

   logic [OW-1:0] cand [4];
   logic          ovf  [4];

   for (genvar g = 0; g < 4; g++) begin : g_mode
      localparam int KEEP = (g == 3) ? OW : (8 + 2 * g);
      localparam int DROP = OW - KEEP;
      if (DROP == 0) begin : g_pass
         assign cand[g] = val;
         assign ovf[g]  = 1'b0;
      end else begin : g_rnd
         localparam logic [OW:0]   HALF     = (OW+1)'(1) << (DROP - 1);
         localparam logic [OW-1:0] KEEPMASK = {OW{1'b1}} << DROP;
         logic [OW:0] ext, sum;
         assign ext     = tag_i.fmt_uns ? {1'b0, val} : {val[OW-1], val};
         assign sum     = ext + HALF;
         assign ovf[g]  = tag_i.fmt_uns ? sum[OW] : (!sum[OW] && sum[OW-1]);
         assign cand[g] = sum[OW-1:0] & KEEPMASK;

         AST_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (tag_i.rnd == 2'(g)) |=>
            (dout[DROP-1:0] == '0 || dout == CLAMP_U || dout == CLAMP_S)); // R5
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
         dvld <= 1'b0;
      end else begin
         dvld <= tag_i.vld;
         if (ovf[tag_i.rnd]) dout <= tag_i.fmt_uns ? CLAMP_U : CLAMP_S;
         else                dout <= cand[tag_i.rnd];
      end
   end

   AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
      (tag_i.rnd == RND_FULL) |=> (dout == $past(val))); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (!tag_i.fmt_uns && !val[OW-1]) |=> !dout[OW-1]); // R7

endmodule

// File: rtl/vmix_blend.sv
module vmix_blend
   import vmix_pkg::*;
#(
   parameter int DW = 12,
   parameter int MW = 12,
   parameter int OW = DW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   input  logic [MW-1:0] m_in,
   input  logic          mix_en,
   input  logic          fmt_uns,
   input  logic [1:0]    rnd_sel,
   input  logic          out_en,
   output logic [OW-1:0] dout,
   output logic          out_vld,
   output logic          out_drive
);
   localparam int TAG_STAGES = 4;

   if (DW < 11) begin : g_bad_dw
      $error("vmix_blend: DW must be at least 11");
   end
   if (MW < 2) begin : g_bad_mw
      $error("vmix_blend: MW must be at least 2");
   end
   if (OW != DW + 1) begin : g_bad_ow
      $error("vmix_blend: OW must equal DW + 1");
   end

   // stage 1: capture samples and their side information
   logic [DW-1:0]     a_s1, b_s1;
   smp_tag_t          tag_q [TAG_STAGES];
   logic signed [DW:0] a_s2, b_s2;
   logic [MW-1:0]     m_eff, m_inv;
   logic [OW-1:0]     val_s4;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_s1     <= '0;
         b_s1     <= '0;
         tag_q[0] <= '0;
      end else begin
         a_s1     <= a_in;
         b_s1     <= b_in;
         tag_q[0] <= '{vld: in_vld, fmt_uns: fmt_uns, rnd: rnd_sel};
      end
   end

   // side information delay line, same depth as the data path
   for (genvar s = 1; s < TAG_STAGES; s++) begin : g_tag
      always_ff @(posedge clk) begin
         if (rst) tag_q[s] <= '0;
         else     tag_q[s] <= tag_q[s-1];
      end
   end

   // stage 2: format-dependent extension to signed operands
   always_ff @(posedge clk) begin
      if (rst) begin
         a_s2 <= '0;
         b_s2 <= '0;
      end else if (tag_q[0].fmt_uns) begin
         a_s2 <= $signed({1'b0, a_s1});
         b_s2 <= $signed({1'b0, b_s1});
      end else begin
         a_s2 <= $signed({a_s1[DW-1], a_s1});
         b_s2 <= $signed({b_s1[DW-1], b_s1});
      end
   end

   vmix_coef #(.MW(MW)) u_coef (
      .clk    (clk),
      .rst    (rst),
      .mix_en (mix_en),
      .m_in   (m_in),
      .m_eff  (m_eff),
      .m_inv  (m_inv)
   );

   vmix_mac #(.DW(DW), .MW(MW), .OW(OW)) u_mac (
      .clk   (clk),
      .rst   (rst),
      .a_x   (a_s2),
      .b_x   (b_s2),
      .m_eff (m_eff),
      .m_inv (m_inv),
      .val   (val_s4)
   );

   vmix_round #(.OW(OW)) u_round (
      .clk   (clk),
      .rst   (rst),
      .val   (val_s4),
      .tag_i (tag_q[TAG_STAGES-1]),
      .dout  (dout),
      .dvld  (out_vld)
   );

   always_ff @(posedge clk) begin
      if (rst) out_drive <= 1'b0;
      else     out_drive <= out_en;
   end

   // cycles since reset, for history-based checks
   logic [2:0] age;
   always_ff @(posedge clk) begin
      if (rst)             age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5) |-> (out_vld == $past(in_vld, 5))); // R1

   AST_OE_REG: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd1) |-> (out_drive == $past(out_en))); // R9

endmodule

// File: tb/tb_vmix_blend.sv
module tb_vmix_blend;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [11:0] a_in = '0, b_in = '0, m_in = '0;
   logic        mix_en = 1'b0, fmt_uns = 1'b1, out_en = 1'b0;
   logic [1:0]  rnd_sel = 2'b11;
   logic [12:0] dout;
   logic        out_vld, out_drive;

   always #2 clk = ~clk;

   vmix_blend dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .a_in(a_in), .b_in(b_in),
      .m_in(m_in), .mix_en(mix_en), .fmt_uns(fmt_uns), .rnd_sel(rnd_sel),
      .out_en(out_en), .dout(dout), .out_vld(out_vld), .out_drive(out_drive)
   );

   int    nchk = 0, nfail = 0, n = 0;
   int    exp_d [8];
   bit    exp_v [8];
   string exp_t [8];
   bit    prev_oe = 1'b0;
   int    held = 0;
   bit    done = 1'b0;

   function automatic int model(int a, int b, int m, bit fu, int rs);
      int me, mi, sa, sb, s, v, drop, r;
      me = (m >= 2048) ? 2048 : m;
      mi = 2048 - me;
      sa = fu ? a : ((a >= 2048) ? a - 4096 : a);
      sb = fu ? b : ((b >= 2048) ? b - 4096 : b);
      s  = sa * me + sb * mi;
      v  = s >>> 10;
      drop = (rs == 0) ? 5 : (rs == 1) ? 3 : (rs == 2) ? 1 : 0;
      if (drop == 0) return v & 8191;
      r = v + (1 << (drop - 1));
      if (fu && r > 8191) return 8191;
      if (!fu && r > 4095) return 4095;
      r = r & ~((1 << drop) - 1);
      return r & 8191;
   endfunction

   task automatic chk(input string tg, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
      end
   endtask

   task automatic step(input bit r, input bit v, input int a, input int b,
                       input int m, input bit en, input bit fu, input int rs,
                       input bit oe, input string tg);
      int idx;
      @(negedge clk);
      if (n >= 5) begin
         idx = (n - 5) % 8;
         chk(exp_t[idx], int'(dout), exp_d[idx]);
         chk({exp_t[idx], " valid"}, int'(out_vld), int'(exp_v[idx]));
      end
      if (n >= 1) chk("R9 out_drive", int'(out_drive), int'(prev_oe));
      rst = r; in_vld = v; a_in = 12'(a); b_in = 12'(b); m_in = 12'(m);
      mix_en = en; fmt_uns = fu; rnd_sel = 2'(rs); out_en = oe;
      idx = n % 8;
      if (r) begin
         held = 0;
         prev_oe = 1'b0;
         for (int i = 0; i < 8; i++) begin
            exp_d[i] = 0; exp_v[i] = 1'b0; exp_t[i] = "R8 reset clear";
         end
      end else begin
         if (en) held = m;
         exp_d[idx] = model(a, b, held, fu, rs);
         exp_v[idx] = v;
         exp_t[idx] = tg;
         prev_oe = oe;
      end
      n++;
   endtask

   initial begin
      #400000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < 3; i++) step(1, 1, 4095, 4095, 2047, 1, 1, 0, 1, "R8");
      // reset state observed on the following idle cycles
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 3, 0, "R8 idle");
      // saturation boundary
      step(0, 1, 100, 3000, 12'h800, 1, 1, 3, 1, "R2 m=1.0");
      step(0, 1, 100, 3000, 12'hFFF, 1, 1, 3, 0, "R2 msb saturate");
      step(0, 1, 100, 3000, 12'h7FF, 1, 1, 3, 1, "R1 below one");
      step(0, 1, 1000, 3000, 12'h400, 1, 1, 3, 1, "R1 half mix");
      step(0, 1, 1000, 3000, 0, 1, 1, 3, 0, "R1 m=0");
      // hold coefficient
      step(0, 1, 1000, 3000, 12'h200, 1, 1, 3, 1, "R3 load");
      step(0, 1, 1000, 3000, 12'hFFF, 0, 1, 3, 1, "R3 ignored bus");
      step(0, 0, 500, 2500, 12'h000, 0, 1, 3, 0, "R3 ignored bus");
      step(0, 1, 4000, 10, 12'h7AB, 0, 1, 3, 1, "R3 ignored bus");
      // per-sample format
      step(0, 1, 12'h800, 12'h800, 12'h400, 1, 0, 3, 1, "R4 most negative");
      step(0, 1, 12'h800, 12'h800, 12'h400, 1, 1, 3, 1, "R4 same bits unsigned");
      step(0, 1, 12'hF00, 12'h100, 12'h555, 1, 0, 3, 0, "R4 mixed sign");
      step(0, 1, 12'hFFF, 12'h001, 12'h123, 1, 0, 2, 1, "R4 floor negative");
      // per-sample rounding
      for (int rs = 0; rs < 4; rs++) begin
         step(0, 1, 1234, 567, 12'h3A1, 1, 1, rs, 1, "R5 precision");
         step(0, 1, 12'hC35, 12'h2A7, 12'h5E3, 1, 0, rs, 0, "R6 round signed");
      end
      step(0, 1, 23, 23, 12'h800, 1, 1, 0, 1, "R6 46 rounds to 32");
      step(0, 1, 24, 24, 12'h800, 1, 1, 0, 1, "R6 48 rounds to 64");
      step(0, 1, 12'hFF4, 0, 12'h800, 1, 0, 1, 1, "R6 negative half");
      // overflow clamp
      step(0, 1, 4095, 4095, 12'h400, 1, 1, 0, 1, "R7 unsigned clamp");
      step(0, 1, 2047, 2047, 12'h400, 1, 0, 0, 1, "R7 signed clamp");
      step(0, 1, 2047, 2047, 12'h400, 1, 0, 2, 0, "R7 signed 12 bit");
      step(0, 1, 4095, 4095, 12'h400, 1, 1, 1, 1, "R7 unsigned 10 bit");
      // random traffic
      for (int i = 0; i < 3000; i++)
         step(0, 1'($urandom), int'($urandom % 4096), int'($urandom % 4096),
              int'($urandom % 4096), ($urandom % 4) != 0, 1'($urandom),
              int'($urandom % 4), 1'($urandom), "R1 random");
      // mid-stream reset
      step(1, 1, 4095, 4095, 12'h600, 1, 1, 3, 1, "R8");
      for (int i = 0; i < 6; i++) step(0, 0, 10, 20, 0, 0, 1, 3, 0, "R8 after reset");
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 3, 0, "R1 flush");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule